// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank with Carry Reporting

This block holds a bank of small event counters for an Ethernet MAC. Each counter is fed by a one-cycle strobe from the transmit or receive datapath: a CRC error, an alignment error, an oversize frame, a collision or a deferral. The counters are deliberately narrow, either 12 or 16 bits wide. They are not made wider in hardware. Instead, each counter sets a sticky carry bit when it rolls over to zero.

Host software extends the counts itself. It reads the two carry registers, adds one full counter revolution to its own totals for every set bit, and writes the value it read back to clear those bits.

Each carry register has a mask register beside it. Any carry bit that is set and not masked drives a single registered interrupt line.

All counters, both carry registers and both masks sit on a plain register bus. A write takes effect at the next clock edge. A read is answered combinationally in the same cycle.

Counters are split into two groups. Group 1 reports into carry register 1 and group 2 reports into carry register 2. Counter i of a group owns carry bit i of that group's register.

Top module: `mac_stat_carry`

## Requirements
- R1: A counter whose event strobe is high at a clock edge, with no bus write to that counter, increases by exactly one at that edge. All counters count independently, including when several strobes are high in the same cycle.
- R2: Each counter has its own width. By default, group 1 counters 0, 2, 3, 6, 7 and 14 are 16 bits wide and roll from 0xFFFF to 0. All other counters are 12 bits wide and roll from 0xFFF to 0. A read returns the counter zero-extended. A write keeps only the low bits that fit the counter's width.
- R3: When a counter rolls over, its carry bit is set at the same edge. A set carry bit stays set until software clears it.
- R4: Writing the carry register clears every carry bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: If a rollover and a clearing write hit the same carry bit at the same edge, the bit ends up set.
- R6: A bus write loads a counter, so writing 0 clears it. If a counter is written and strobed at the same edge, the written value is kept. The increment is dropped and no carry is raised.
- R7: In a mask register, a bit at 1 masks the matching carry bit. After reset, mask 1 holds the low 16 bits of 0xFFFFBE32 (0xBE32). Mask 2 holds the low 17 bits of 0xFFFE7E8B (0x07E8B). Both masks are writable and can be read back.
- R8: stat_irq is registered. It goes high one clock after any carry bit whose mask bit is 0 becomes set. It goes low one clock after the last such bit is cleared or masked. It is low during and after reset.
- R9: The address map is as follows:
  - Group 1 counter i is at address i.
  - Group 2 counter j is at address 32+j.
  - Carry register 1 is at 64 and carry register 2 is at 65.
  - Mask 1 is at 66 and mask 2 is at 67.
  - Unmapped addresses read as 0.
- R10: Reset sets every counter and both carry registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_grp1 | input | N1 | Event strobes for group 1 counters |
| ev_grp2 | input | N2 | Event strobes for group 2 counters |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Read data for bus_addr, same cycle |
| stat_irq | output | 1 | Interrupt from unmasked carry bits |

## Verification
The results of this block fall due at different times:
- A counter value or a carry bit changes at the clock edge where the strobe or write is sampled.
- The interrupt follows one edge later, because it is registered from the carry and mask state.
- Read data is combinational, so it is valid in the same cycle as the address.

The bench drives inputs on the falling edge and samples each result on a later falling edge. Counter and carry checks wait one edge after the stimulus. Interrupt checks are made both one edge and two edges after a carry or mask change, which pins down the single-cycle lag. The sweeps run the 12-bit counter through all 4096 values. Every counter is preloaded to near its maximum, so its rollover and carry bit are exercised with expected values computed from its width.

// File: rtl/mac_stat_carry.sv
module mac_stat_carry #(
  parameter int N1       = 16,
  parameter int N2       = 17,
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 12,
  parameter int AW       = 7,
  parameter int DW       = 32,
  parameter logic [31:0] WIDE1     = 32'h0000_40CD,
  parameter logic [31:0] WIDE2     = 32'h0000_0000,
  parameter logic [31:0] MASK1_RST = 32'hFFFF_BE32,
  parameter logic [31:0] MASK2_RST = 32'hFFFE_7E8B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N1-1:0] ev_grp1,
  input  logic [N2-1:0] ev_grp2,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          stat_irq
);
  localparam int NT        = N1 + N2;
  localparam int GRP2_BASE = 1 << (AW - 2);
  localparam int REG_BASE  = 1 << (AW - 1);
  localparam logic [AW-1:0] A_CARRY1 = AW'(REG_BASE);
  localparam logic [AW-1:0] A_CARRY2 = AW'(REG_BASE + 1);
  localparam logic [AW-1:0] A_MASK1  = AW'(REG_BASE + 2);
  localparam logic [AW-1:0] A_MASK2  = AW'(REG_BASE + 3);
  localparam logic [NT-1:0] WIDE     = {WIDE2[N2-1:0], WIDE1[N1-1:0]};

  function automatic int cnt_addr(input int k);
    return (k < N1) ? k : GRP2_BASE + k - N1;
  endfunction

  logic [WIDE_W-1:0] cnt_q [NT];
  logic [NT-1:0]     ev, wrap, cnt_wr, carry_q, carry_clr;
  logic [N1-1:0]     mask1_q, carry1;
  logic [N2-1:0]     mask2_q, carry2;
  logic              wr_c1, wr_c2;
  logic              unused_wdata;

  assign ev     = {ev_grp2, ev_grp1};
  assign carry1 = carry_q[N1-1:0];
  assign carry2 = carry_q[NT-1:N1];
  assign wr_c1  = bus_wr && (bus_addr == A_CARRY1);
  assign wr_c2  = bus_wr && (bus_addr == A_CARRY2);
  assign carry_clr = {wr_c2 ? bus_wdata[N2-1:0] : {N2{1'b0}},
                      wr_c1 ? bus_wdata[N1-1:0] : {N1{1'b0}}};
  assign unused_wdata = &{1'b0, bus_wdata};

  for (genvar i = 0; i < NT; i++) begin : g_cnt
    localparam int W = WIDE[i] ? WIDE_W : NARROW_W;
    logic [W-1:0] val;
    assign val       = cnt_q[i][W-1:0];
    assign cnt_wr[i] = bus_wr && (bus_addr == AW'(cnt_addr(i)));
    assign wrap[i]   = ev[i] && !cnt_wr[i] && (&val);
    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q[i] <= '0;
      else if (cnt_wr[i]) cnt_q[i] <= WIDE_W'(bus_wdata[W-1:0]);
      else if (ev[i])     cnt_q[i] <= WIDE_W'(W'(val + 1'b1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q  <= '0;
      mask1_q  <= MASK1_RST[N1-1:0];
      mask2_q  <= MASK2_RST[N2-1:0];
      stat_irq <= 1'b0;
    end else begin
      carry_q  <= (carry_q & ~carry_clr) | wrap;
      stat_irq <= |(carry_q & ~{mask2_q, mask1_q});
      if (bus_wr && bus_addr == A_MASK1) mask1_q <= bus_wdata[N1-1:0];
      if (bus_wr && bus_addr == A_MASK2) mask2_q <= bus_wdata[N2-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CARRY1: bus_rdata[N1-1:0] = carry1;
      A_CARRY2: bus_rdata[N2-1:0] = carry2;
      A_MASK1:  bus_rdata[N1-1:0] = mask1_q;
      A_MASK2:  bus_rdata[N2-1:0] = mask2_q;
      default: begin
        for (int k = 0; k < NT; k++)
          if (bus_addr == AW'(cnt_addr(k))) bus_rdata[WIDE_W-1:0] = cnt_q[k];
      end
    endcase
  end
endmodule

// File: rtl/mac_stat_carry_chk.sv
module mac_stat_carry_chk #(
  parameter int N1 = 16,
  parameter int N2 = 17,
  parameter int WIDE_W = 16,
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int WA = 16,
  parameter int WB = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N1-1:0]     ev_grp1,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              stat_irq,
  input logic [N1-1:0]     carry1,
  input logic [N2-1:0]     carry2,
  input logic [N1-1:0]     mask1,
  input logic [N2-1:0]     mask2,
  input logic [WIDE_W-1:0] cnt_a,
  input logic [WIDE_W-1:0] cnt_b
);
  localparam logic [AW-1:0]     A_C1 = AW'(1 << (AW - 1));
  localparam logic [WIDE_W-1:0] MAXA = WIDE_W'((1 << WA) - 1);
  localparam logic [WIDE_W-1:0] MAXB = WIDE_W'((1 << WB) - 1);

  logic wr_a, wr_b, wr_c1, pend;
  assign wr_a  = bus_wr && bus_addr == AW'(0);
  assign wr_b  = bus_wr && bus_addr == AW'(1);
  assign wr_c1 = bus_wr && bus_addr == A_C1;
  assign pend  = |({carry2, carry1} & ~{mask2, mask1});

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grp1[0] && !wr_a && cnt_a != MAXA) |=> cnt_a == WIDE_W'($past(cnt_a) + 1'b1)) else $error("count step"); // R1
  AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grp1[1] && !wr_b && cnt_b == MAXB) |=> cnt_b == '0) else $error("narrow wrap"); // R2
  AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_grp1[0] && !wr_a && cnt_a == MAXA) |=> (cnt_a == '0 && carry1[0])) else $error("wide wrap"); // R3
  AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c1 |=> ((carry1 & $past(carry1)) == $past(carry1))) else $error("carry sticky"); // R3
  AST_CARRY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && bus_wdata[0] && !ev_grp1[0]) |=> !carry1[0]) else $error("carry clear"); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && bus_wdata[0] && ev_grp1[0] && cnt_a == MAXA) |=> carry1[0]) else $error("set vs clear"); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> cnt_a == ($past(bus_wdata[WIDE_W-1:0]) & MAXA)) else $error("write wins"); // R6
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> stat_irq) else $error("irq rise"); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !stat_irq) else $error("irq fall"); // R8
endmodule

bind mac_stat_carry mac_stat_carry_chk #(
  .N1(N1), .N2(N2), .WIDE_W(WIDE_W), .AW(AW), .DW(DW),
  .WA(WIDE1[0] ? WIDE_W : NARROW_W), .WB(WIDE1[1] ? WIDE_W : NARROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_grp1(ev_grp1), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_irq(stat_irq),
  .carry1(carry1), .carry2(carry2), .mask1(mask1_q), .mask2(mask2_q),
  .cnt_a(cnt_q[0]), .cnt_b(cnt_q[1])
);

// File: tb/test_mac_stat_carry.sv
module test_mac_stat_carry;
  localparam int N1 = 16, N2 = 17, NT = N1 + N2;
  localparam logic [31:0] WIDE1 = 32'h0000_40CD;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [NT-1:0] ev_all = '0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, d;
  logic stat_irq;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  mac_stat_carry i_mac_stat_carry (
    .clk(clk), .rst_n(rst_n), .ev_grp1(ev_all[N1-1:0]), .ev_grp2(ev_all[NT-1:N1]),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_irq(stat_irq));

  function automatic int w_of(int k);
    return (k < N1 && WIDE1[k]) ? 16 : 12;
  endfunction
  function automatic int a_of(int k);
    return (k < N1) ? k : 32 + k - N1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); bus_addr = 7'(a); #1 v = bus_rdata;
  endtask
  task automatic wr(int a, logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic pulse(int k, int n);
    @(negedge clk); ev_all[k] = 1'b1;
    repeat (n) @(negedge clk);
    ev_all[k] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 irq in reset", 32'(stat_irq), 0);
    rst_n = 1'b1;
    // R10 / R7 / R9 reset state and map
    for (int k = 0; k < NT; k++) begin rd(a_of(k), d); chk("R10 counter reset", d, 0); end
    rd(64, d); chk("R10 carry1 reset", d, 0);
    rd(65, d); chk("R10 carry2 reset", d, 0);
    rd(66, d); chk("R7 mask1 reset", d, 32'h0000_BE32);
    rd(67, d); chk("R7 mask2 reset", d, 32'h0000_7E8B);
    rd(70, d); chk("R9 unmapped read", d, 0);
    rd(20, d); chk("R9 gap read", d, 0);
    chk("R8 irq after reset", 32'(stat_irq), 0);

    // R1 individual and simultaneous counting
    for (int k = 0; k < NT; k++) pulse(k, k % 5 + 1);
    @(negedge clk); ev_all = '1; repeat (3) @(negedge clk); ev_all = '0;
    for (int k = 0; k < NT; k++) begin rd(a_of(k), d); chk("R1 count", d, 32'(k % 5 + 4)); end
    rd(64, d); chk("R3 no carry without wrap", d, 0);

    // R6 write zero clears
    for (int k = 0; k < NT; k++) wr(a_of(k), 0);
    for (int k = 0; k < NT; k++) begin rd(a_of(k), d); chk("R6 clear by write", d, 0); end

    // R2 exhaustive 12-bit sweep of counter 1
    pulse(1, 4095);
    rd(1, d); chk("R2 narrow max", d, 32'hFFF);
    rd(64, d); chk("R3 no carry before wrap", d, 0);
    pulse(1, 1);
    rd(1, d); chk("R2 narrow wrap", d, 0);
    rd(64, d); chk("R3 carry on wrap", d, 32'h2);
    @(negedge clk); chk("R7 masked carry no irq", 32'(stat_irq), 0);

    // R2 / R3 rollover of every counter
    for (int k = 0; k < NT; k++) begin
      wr(a_of(k), 32'hFFFF_FFFF);
      rd(a_of(k), d); chk("R2 write truncation", d, 32'((1 << w_of(k)) - 1));
      pulse(k, 3);
      rd(a_of(k), d); chk("R2 rollover value", d, 2);
    end
    rd(64, d); chk("R3 carry1 all", d, 32'h0000_FFFF);
    rd(65, d); chk("R3 carry2 all", d, 32'h0001_FFFF);
    chk("R8 irq with unmasked carry", 32'(stat_irq), 1);

    // R4 clear on write one
    wr(64, 0);         rd(64, d); chk("R4 write zero keeps", d, 32'h0000_FFFF);
    wr(64, 32'h00FF);  rd(64, d); chk("R4 partial clear", d, 32'h0000_FF00);
    wr(64, 32'hFF00);  rd(64, d); chk("R4 clear rest", d, 0);
    wr(65, 32'h1FFFF); rd(65, d); chk("R4 clear carry2", d, 0);
    @(negedge clk); chk("R8 irq falls", 32'(stat_irq), 0);

    // R8 exact timing
    wr(0, 32'hFFFF);
    @(negedge clk); ev_all[0] = 1'b1;
    @(negedge clk); ev_all[0] = 1'b0;
    chk("R8 irq not yet", 32'(stat_irq), 0);
    @(negedge clk); chk("R8 irq one edge later", 32'(stat_irq), 1);
    wr(66, 32'hBE33);
    chk("R8 irq before mask seen", 32'(stat_irq), 1);
    @(negedge clk); chk("R7 mask removes irq", 32'(stat_irq), 0);
    rd(66, d); chk("R7 mask readback", d, 32'hBE33);
    wr(66, 32'hBE32);
    @(negedge clk); chk("R7 unmask restores irq", 32'(stat_irq), 1);
    wr(64, 32'hFFFF);

    // R5 set and clear same edge
    wr(2, 32'hFFFF);
    @(negedge clk); ev_all[2] = 1'b1; bus_wr = 1'b1; bus_addr = 7'd64; bus_wdata = 32'h4;
    @(negedge clk); ev_all[2] = 1'b0; bus_wr = 1'b0;
    rd(64, d); chk("R5 set beats clear", d, 32'h4);
    rd(2, d);  chk("R5 counter wrapped", d, 0);

    // R6 write wins over event, no carry
    wr(5, 32'hFFF);
    @(negedge clk); ev_all[5] = 1'b1; bus_wr = 1'b1; bus_addr = 7'd5; bus_wdata = 32'h123;
    @(negedge clk); ev_all[5] = 1'b0; bus_wr = 1'b0;
    rd(5, d);  chk("R6 write wins", d, 32'h123);
    rd(64, d); chk("R6 no carry on write", d, 32'h4);
    wr(32 + 3, 32'hFFF);
    @(negedge clk); ev_all[N1 + 3] = 1'b1; bus_wr = 1'b1; bus_addr = 7'd35; bus_wdata = 32'h0;
    @(negedge clk); ev_all[N1 + 3] = 1'b0; bus_wr = 1'b0;
    rd(35, d); chk("R6 group2 write wins", d, 0);
    rd(65, d); chk("R6 group2 no carry", d, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule